// File: doc/BRIEF.md
# Polarity-Selectable Edge Pulse Machine

This block watches one input line and raises its output for a single clock once the line has moved from its resting level to the active level. A parameter selects which level is active. The machine first waits for the line to sit at the opposite, resting level. It then arms, and it fires when the line leaves that resting level. A second parameter selects whether the state register updates on the rising or on the falling edge of the clock.

The state is held in a 2-bit register with fixed codes. The one code that no legal transition reaches returns to the idle code on the next update. A flipped state bit therefore cannot lock the machine up. An active-low reset returns the machine to idle at once, without waiting for a clock edge. The output depends only on the current state.

Top module: `edge_pulse_fsm`

## Requirements
- R1: While `resetn` is low, the state is forced to idle (code 00) without waiting for a clock edge, and `result` is 0.
- R2: In idle (code 00), `result` is 0. Idle is kept while `sig` equals the active level `EDGE_LVL`.
- R3: From idle, armed or fired, `sig` at the resting level (the inverse of `EDGE_LVL`) moves the machine to armed (code 01) at the next update. Armed also gives `result` = 0.
- R4: From armed, `sig` at the active level moves the machine to fired (code 10), and `result` is 1 for the clock period that follows.
- R5: From fired, `sig` at the active level returns the machine to idle. `result` is never high for two consecutive updates.
- R6: Code 11 gives `result` = 0 and goes to idle at the next update, whatever `sig` is.
- R7: With `EDGE_LVL` = 1 a low-to-high move of `sig` is detected. With `EDGE_LVL` = 0 a high-to-low move is detected.
- R8: With `CLK_RISE` = 1 the state updates on the rising edge of `clk`. With `CLK_RISE` = 0 it updates on the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is selected by `CLK_RISE` |
| resetn | input | 1 | Asynchronous reset, active low |
| sig | input | 1 | Line being watched |
| result | output | 1 | High for one clock after a detected edge |

## Verification
The fired state can coincide with re-arming: when `sig` toggles on every update, the machine leaves fired straight for armed, and pulses must appear on every second clock rather than being merged or lost. The bench provokes this with an alternating pattern and with random streams on two instances: one detects rising edges on the rising clock edge, the other detects falling edges on the falling clock edge. Both are judged against a bench-side transition function. The bench also asserts reset, and separately forces the unused code, just after a pulse has started. In both cases it checks that `result` drops, and that the forced code returns to idle rather than to armed.

// File: rtl/edge_pulse_fsm.sv
module edge_pulse_fsm #(
  parameter bit EDGE_LVL = 1'b1,
  parameter bit CLK_RISE = 1'b1
) (
  input  logic clk,
  input  logic resetn,
  input  logic sig,
  output logic result
);

  localparam logic [1:0] ST_IDLE  = 2'b00;
  localparam logic [1:0] ST_ARMED = 2'b01;
  localparam logic [1:0] ST_HIT   = 2'b10;
  localparam logic [1:0] ST_BAD   = 2'b11;

  logic [1:0] state_q, state_d;
  logic sclk, at_rest;

  assign sclk    = CLK_RISE ? clk : ~clk;
  assign at_rest = (sig == ~EDGE_LVL);

  always_comb begin
    case (state_q)
      ST_IDLE:  state_d = at_rest ? ST_ARMED : ST_IDLE;
      ST_ARMED: state_d = at_rest ? ST_ARMED : ST_HIT;
      ST_HIT:   state_d = at_rest ? ST_ARMED : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge sclk or negedge resetn) begin
    if (!resetn) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign result = (state_q == ST_HIT);

  AST_RESET_IDLE: assert property (@(posedge sclk) !resetn |-> (state_q == ST_IDLE && !result)); // R1
  AST_IDLE_HOLD: assert property (@(posedge sclk) disable iff (!resetn)
    (state_q == ST_IDLE && sig == EDGE_LVL) |=> state_q == ST_IDLE); // R2
  AST_ARM_ON_REST: assert property (@(posedge sclk) disable iff (!resetn)
    (state_q != ST_BAD && sig != EDGE_LVL) |=> state_q == ST_ARMED); // R3
  AST_HIT_FROM_ARMED: assert property (@(posedge sclk) disable iff (!resetn)
    state_q == ST_HIT |-> ($past(state_q) == ST_ARMED && $past(sig) == EDGE_LVL)); // R4
  AST_ONE_CLOCK_PULSE: assert property (@(posedge sclk) disable iff (!resetn)
    result |=> !result); // R5
  AST_BAD_RECOVERS: assert property (@(posedge sclk) disable iff (!resetn)
    state_q == ST_BAD |=> state_q == ST_IDLE); // R6

endmodule

// File: tb/tb_edge_pulse_fsm.sv
`timescale 1ns/1ps
module tb_edge_pulse_fsm;
  logic clk = 1'b0;
  logic resetn = 1'b0;
  logic sig = 1'b0;
  logic res_r, res_f;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int ma = 0;
  int mf = 0;

  always #2.5 clk = ~clk;

  // R7/R8: default instance detects rising sig edges on rising clock edges
  edge_pulse_fsm dut (.clk(clk), .resetn(resetn), .sig(sig), .result(res_r));
  // R7/R8: second instance detects falling sig edges on falling clock edges
  edge_pulse_fsm #(.EDGE_LVL(1'b0), .CLK_RISE(1'b0)) dut_fall (
    .clk(clk), .resetn(resetn), .sig(sig), .result(res_f));

  function automatic int nxt(int st, logic s, logic lvl);
    if (st == 3) return 0;
    if (s != lvl) return 1;
    if (st == 1) return 2;
    return 0;
  endfunction

  function automatic string tag(int p, int n);
    if (p == 3) return "R6";
    if (n == 1) return "R3";
    if (n == 2) return "R4";
    if (p == 2) return "R5";
    return "R2";
  endfunction

  task automatic chk(string rq, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic cycle(logic s);
    int p;
    sig = s;
    @(negedge clk);
    p = mf; mf = nxt(mf, s, 1'b0);
    #1 chk({"R7 R8 ", tag(p, mf)}, res_f, mf == 2);
    @(posedge clk);
    p = ma; ma = nxt(ma, s, 1'b1);
    #1 chk(tag(p, ma), res_r, ma == 2);
  endtask

  initial begin
    int r;
    r = $urandom(32'hC0DE);
    #1;
    chk("R1", res_r, 1'b0);
    chk("R1", res_f, 1'b0);
    sig = 1'b1;
    @(negedge clk); #1 chk("R1", res_f, 1'b0);
    @(posedge clk); #1 chk("R1", res_r, 1'b0);
    resetn = 1'b1;

    cycle(1'b1); cycle(1'b1);
    cycle(1'b0); cycle(1'b1); cycle(1'b1); cycle(1'b1);
    for (int i = 0; i < 12; i++) cycle(i[0]);   // re-arm while fired, R3 and R5
    cycle(1'b0); cycle(1'b0); cycle(1'b0); cycle(1'b1); cycle(1'b0);

    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      if (r[3:2] == 2'b00) cycle(~sig);
      else cycle(r[0]);
    end

    // R6: force the unused code just after a pulse begins
    cycle(1'b0); cycle(1'b1);
    chk("R4", res_r, 1'b1);
    force dut.state_q = 2'b11;
    #0.5 chk("R6", res_r, 1'b0);
    ma = 3;
    release dut.state_q;
    cycle(1'b1);
    cycle(1'b1);
    cycle(1'b0); cycle(1'b1);

    // R1: asynchronous reset during a pulse
    cycle(1'b0); cycle(1'b1);
    chk("R4", res_r, 1'b1);
    resetn = 1'b0;
    #0.5 chk("R1", res_r, 1'b0);
    ma = 0; mf = 0;
    sig = 1'b0;
    @(negedge clk); #1 chk("R1", res_f, 1'b0);
    @(posedge clk); #1 chk("R1", res_r, 1'b0);
    sig = 1'b1;
    resetn = 1'b1;
    cycle(1'b1); cycle(1'b0); cycle(1'b1); cycle(1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule